// File: doc/BRIEF.md
# I2C Controller Register Front End

This block is the software-visible side of an I2C master/slave controller. It decodes byte-wide reads and writes on a simple synchronous bus that has a select, a write flag, an offset and 8-bit data in each direction. Behind that bus it holds the control byte, the status byte, the clock-divider byte and the filter byte. It drives one level-sensitive interrupt line. Waveform generation, clock division and glitch filtering live in a separate bus engine.

Reads of the data register are pipelined. Each read returns the byte fetched by the read before it. When the controller is in a state that can receive, the same read asks the bus engine for the next byte. That request is a single-cycle strobe. The engine answers later with a valid strobe and the byte. The byte is then buffered, the interrupt-pending flag is raised and the received-acknowledge flag is cleared. If a data read happens while the controller cannot receive, the buffer is filled with 0xFF instead, so software sees 0xFF on its next data read.

Top module: `i2c_regfront`

## Requirements
- R1: After reset, control, status, divider, filter and the data buffer are all zero. The interrupt and the receive request are low.
- R2: The divider (offset 0x04) and the filter (offset 0x14) read back the last byte written to them. The offset 0x00 always reads 0, and writes to it have no visible effect.
- R3: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 returns 0xFF.
- R4: The control register (offset 0x08) stores the whole written byte. It reads back with bits 2 and 1 forced to 0.
- R5: A status write (offset 0x0C) stores bits 7..2 and bit 0 as written. Bit 1 (interrupt pending) is cleared when it is written as 0 and kept when it is written as 1; a write can never set it.
- R6: The interrupt output is high exactly when control bit 6 (interrupt enable) and status bit 1 (interrupt pending) are both 1.
- R7: A data read (offset 0x10) returns the buffered byte on the same cycle. It raises the receive request for exactly that cycle if all of the following hold: control bit 7 (enable) is 1, status bit 5 (bus busy) is 1, the engine's active input is 1, control bit 4 (transmit mode) is 0, and no receive is outstanding.
- R8: When the engine's valid strobe arrives for an outstanding receive, the byte is loaded into the buffer, status bit 1 is set and status bit 0 is cleared.
- R9: A data read that fails any of the R7 conditions other than the outstanding one loads 0xFF into the buffer and raises no request.
- R10: While a receive is outstanding, a data read raises no request and leaves the buffer unchanged. A valid strobe that arrives with no receive outstanding changes neither the buffer nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |
| eng_active | input | 1 | Bus engine has an addressed transaction in progress |
| eng_req | output | 1 | One-cycle request for one received byte |
| eng_valid | input | 1 | Requested byte is present on eng_byte |
| eng_byte | input | 8 | Byte from the bus engine |

## Verification
The receive gate is tried with all sixteen combinations of enable, bus busy, engine active and transmit mode. Only one of them may raise a request and load a real byte; the other fifteen must load 0xFF, which the next read then exposes. Every byte value is written to the control, status, divider and filter registers, which separates the read masks from the stored values. Back-to-back data reads with a receive outstanding, and a valid strobe that nothing asked for, separate the outstanding-request guard from the ordinary path. The undefined offsets are swept across the whole address range.

// File: rtl/i2c_regfront.sv
module i2c_regfront #(
  parameter int ADDR_W   = 5,
  parameter int OFF_OWN  = 'h00,
  parameter int OFF_DIV  = 'h04,
  parameter int OFF_CTRL = 'h08,
  parameter int OFF_STAT = 'h0C,
  parameter int OFF_DATA = 'h10,
  parameter int OFF_FILT = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  input  logic              eng_active,
  output logic              eng_req,
  input  logic              eng_valid,
  input  logic [7:0]        eng_byte
);
  localparam int C_EN   = 7;
  localparam int C_IE   = 6;
  localparam int C_TX   = 4;
  localparam int S_BUSY = 5;
  localparam int S_PEND = 1;
  localparam int S_RACK = 0;
  localparam logic [7:0] CTRL_RMASK = 8'hF9;

  logic [7:0] ctrl_q, stat_q, div_q, filt_q, buf_q;
  logic       rx_wait_q;

  wire rd = bus_sel && !bus_wr;
  wire wr = bus_sel && bus_wr;
  wire hit_div  = bus_addr == ADDR_W'(OFF_DIV);
  wire hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
  wire hit_stat = bus_addr == ADDR_W'(OFF_STAT);
  wire hit_data = bus_addr == ADDR_W'(OFF_DATA);
  wire hit_filt = bus_addr == ADDR_W'(OFF_FILT);
  wire hit_own  = bus_addr == ADDR_W'(OFF_OWN);

  wire rd_data = rd && hit_data;
  wire rx_ok   = ctrl_q[C_EN] && stat_q[S_BUSY] && eng_active && !ctrl_q[C_TX];
  wire rx_done = eng_valid && rx_wait_q;

  assign eng_req = rd_data && rx_ok && !rx_wait_q;
  assign irq     = ctrl_q[C_IE] && stat_q[S_PEND];

  always_comb begin
    if (hit_own)       bus_rdata = 8'h00;
    else if (hit_div)  bus_rdata = div_q;
    else if (hit_ctrl) bus_rdata = ctrl_q & CTRL_RMASK;
    else if (hit_stat) bus_rdata = stat_q;
    else if (hit_data) bus_rdata = buf_q;
    else if (hit_filt) bus_rdata = filt_q;
    else               bus_rdata = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      stat_q    <= '0;
      div_q     <= '0;
      filt_q    <= '0;
      buf_q     <= '0;
      rx_wait_q <= 1'b0;
    end else begin
      if (wr && hit_ctrl) ctrl_q <= bus_wdata;
      if (wr && hit_div)  div_q  <= bus_wdata;
      if (wr && hit_filt) filt_q <= bus_wdata;
      if (wr && hit_stat)
        stat_q <= {bus_wdata[7:2], bus_wdata[S_PEND] & stat_q[S_PEND], bus_wdata[S_RACK]};
      if (rx_done) begin
        stat_q[S_PEND] <= 1'b1;
        stat_q[S_RACK] <= 1'b0;
        buf_q          <= eng_byte;
      end else if (rd_data && !rx_wait_q && !rx_ok) begin
        buf_q <= 8'hFF;
      end
      if (eng_req)      rx_wait_q <= 1'b1;
      else if (rx_done) rx_wait_q <= 1'b0;
    end
  end
endmodule

module i2c_regfront_chk #(
  parameter int ADDR_W   = 5,
  parameter int OFF_OWN  = 'h00,
  parameter int OFF_CTRL = 'h08,
  parameter int OFF_DATA = 'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              irq,
  input logic              eng_active,
  input logic              eng_req,
  input logic              eng_valid,
  input logic [7:0]        eng_byte,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        stat_q,
  input logic [7:0]        buf_q,
  input logic              rx_wait_q
);
  wire rd_data = bus_sel && !bus_wr && bus_addr == ADDR_W'(OFF_DATA);

  p_own_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFF_OWN)) |-> bus_rdata == 8'h00);

  p_ctrl_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFF_CTRL)) |-> bus_rdata[2:1] == 2'b00);

  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> stat_q[1]);

  p_req_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> (rd_data && eng_active));

  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);

  p_arrival_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && rx_wait_q) |=> (stat_q[1] && !stat_q[0] && buf_q == $past(eng_byte)));

  p_ff_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_wait_q && !ctrl_q[7]) |=> buf_q == 8'hFF);

  p_wait_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wait_q |-> !eng_req);

  p_stray_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !rx_wait_q && !rd_data) |=> $stable(buf_q));
endmodule

bind i2c_regfront i2c_regfront_chk #(
  .ADDR_W(ADDR_W), .OFF_OWN(OFF_OWN), .OFF_CTRL(OFF_CTRL), .OFF_DATA(OFF_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .eng_active(eng_active), .eng_req(eng_req),
  .eng_valid(eng_valid), .eng_byte(eng_byte), .ctrl_q(ctrl_q), .stat_q(stat_q),
  .buf_q(buf_q), .rx_wait_q(rx_wait_q)
);

// File: tb/tb_i2c_regfront.sv
module tb_i2c_regfront;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 5;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq, eng_req;
  logic eng_active = 0, eng_valid = 0;
  logic [7:0] eng_byte = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_buf;
  logic [7:0] rv;
  logic rq;

  always #(CLK_P/2) clk = ~clk;

  i2c_regfront #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .eng_active(eng_active),
    .eng_req(eng_req), .eng_valid(eng_valid), .eng_byte(eng_byte));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d, output logic r);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = ADDR_W'(a);
    #(CLK_P/4);
    d = bus_rdata; r = eng_req;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic deliver(input logic [7:0] b);
    @(negedge clk);
    eng_valid = 1; eng_byte = b;
    @(posedge clk); #1;
    eng_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_P*3); rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 req", {7'b0, eng_req}, 8'h00);
    rd('h08, rv, rq); chk("R1 ctrl", rv, 8'h00);
    rd('h0C, rv, rq); chk("R1 stat", rv, 8'h00);
    rd('h04, rv, rq); chk("R1 div", rv, 8'h00);
    rd('h14, rv, rq); chk("R1 filt", rv, 8'h00);
    rd('h10, rv, rq); chk("R1 buf", rv, 8'h00);
    exp_buf = 8'hFF;

    // R2 divider, filter, own-address sweeps
    for (int v = 0; v < 256; v++) begin
      wr('h04, 8'(v)); wr('h14, 8'(255 - v)); wr('h00, 8'(v));
      rd('h04, rv, rq); chk("R2 div", rv, 8'(v));
      rd('h14, rv, rq); chk("R2 filt", rv, 8'(255 - v));
      rd('h00, rv, rq); chk("R2 own", rv, 8'h00);
    end

    // R3 undefined offsets
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      if (a != 'h00 && a != 'h04 && a != 'h08 && a != 'h0C && a != 'h10 && a != 'h14) begin
        rd(a, rv, rq); chk("R3 undef", rv, 8'hFF);
      end
    end

    // R4 control mask, R5 status store
    for (int v = 0; v < 256; v++) begin
      wr('h08, 8'(v)); rd('h08, rv, rq); chk("R4 ctrl", rv, 8'(v) & 8'hF9);
      wr('h0C, 8'(v)); rd('h0C, rv, rq); chk("R5 stat", rv, 8'(v) & 8'hFD);
    end
    wr('h08, 8'h00); wr('h0C, 8'h00);

    // R7 / R9 / R8 / R6 receive gate sweep
    for (int i = 0; i < 16; i++) begin
      logic en, busy, act, tx, elig;
      logic [7:0] b;
      en = i[0]; busy = i[1]; act = i[2]; tx = i[3];
      elig = en && busy && act && !tx;
      wr('h08, {en, 1'b1, 1'b0, tx, 4'b0});
      wr('h0C, {2'b0, busy, 5'b0});
      eng_active = act;
      rd('h10, rv, rq);
      chk("R7 data returns buffer", rv, exp_buf);
      chk(elig ? "R7 request" : "R9 no request", {7'b0, rq}, {7'b0, elig});
      if (elig) begin
        b = 8'(i * 37 + 11);
        deliver(b);
        exp_buf = b;
        rd('h0C, rv, rq); chk("R8 status flags", rv, {2'b0, busy, 3'b0, 2'b10});
        chk("R6 irq high", {7'b0, irq}, 8'h01);
        wr('h08, {en, 1'b0, 1'b0, tx, 4'b0});
        chk("R6 irq masked", {7'b0, irq}, 8'h00);
      end else begin
        exp_buf = 8'hFF;
        chk("R6 irq idle", {7'b0, irq}, 8'h00);
      end
    end

    // R10 outstanding guard
    wr('h08, 8'h80); wr('h0C, 8'h20); eng_active = 1;
    rd('h10, rv, rq); chk("R7 req eligible", {7'b0, rq}, 8'h01);
    chk("R7 data", rv, exp_buf);
    rd('h10, rv, rq); chk("R10 no second req", {7'b0, rq}, 8'h00);
    chk("R10 buffer kept", rv, exp_buf);
    deliver(8'hC3);
    rd('h10, rv, rq); chk("R8 byte read back", rv, 8'hC3);
    chk("R7 req again", {7'b0, rq}, 8'h01);
    deliver(8'h3C); exp_buf = 8'h3C;
    wr('h0C, 8'h20);
    deliver(8'h99);
    rd('h0C, rv, rq); chk("R10 stray valid status", rv, 8'h20);
    rd('h10, rv, rq); chk("R10 stray valid buffer", rv, 8'h3C);
    deliver(8'h44); exp_buf = 8'h44;

    // R5 pending bit write rules
    wr('h0C, 8'hFF); rd('h0C, rv, rq); chk("R5 pending kept", rv, 8'hFF);
    wr('h0C, 8'hFD); rd('h0C, rv, rq); chk("R5 pending cleared", rv, 8'hFD);
    wr('h0C, 8'h02); rd('h0C, rv, rq); chk("R5 pending not set", rv, 8'h00);

    finish_run();
  end
endmodule